// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a register-mapped up-counter with one compare channel, intended as a general system tick or timeout source. The counter starts at zero and steps forward on prescaled ticks taken from one of two external tick-enable inputs. In restart mode the count returns to zero after it matches the compare value, which gives a period of compare + 1 steps. In free-run mode the count runs through the full range and wraps. Each mode sets sticky status flags, and an interrupt mask gates those flags onto one level-sensitive interrupt line.

Software programs the block through a plain synchronous register bus with byte addresses and word-sized registers. Register writes complete on the clock edge at which `busSel` and `busWrite` are both high. Reads are combinational from `busAddr`. The counter width is a parameter with a default of 32 bits. All other register widths are fixed.

Top module: `match_timer`

## Requirements
- R1: The registers sit at byte offsets 0x00 control, 0x04 prescaler, 0x08 status, 0x0C interrupt mask, 0x10 compare and 0x24 count (read-only). Every other offset reads 0. After reset, control, prescaler, status, mask and count read 0 and compare reads all ones.
- R2: Control bits 15:10 always read 0, and bit 15 is never stored. The prescaler keeps only its low 12 bits. The interrupt mask keeps only its low 6 bits.
- R3: Control bits 8:6 choose the tick source. Codes 001 and 010 select `fastTick`, code 100 selects `slowTick`, and every other code selects no tick.
- R4: While control bit 0 (enable) is 1, the count steps once every (prescaler + 1) selected ticks. While enable is 0, the count holds.
- R5: When control bit 9 is 0 (restart mode), a step taken while count equals compare sets count to 0 and sets status bit 0.
- R6: When control bit 9 is 1 (free-run mode), every step adds 1. A step from all ones wraps to 0 and sets status bit 5. A step taken while count equals compare sets status bit 0. Both flags can be set by the same step.
- R7: Writing status with a 1 in bit 0 or bit 5 clears that flag. All other status bits read 0 and cannot be set by a write. A flag that is set in the same cycle as its clear stays set.
- R8: `irqOut` is 1 exactly when enable is 1 and at least one of status bits 0 and 5 is set together with the matching mask bit.
- R9: A control write that changes enable from 0 to 1 while also setting bit 1 (enable-mode) clears the count. The same change without bit 1 keeps the count.
- R10: In restart mode, any write to compare sets the count and the prescale phase to 0. In free-run mode, a write to compare leaves the count unchanged.
- R11: A control write with bit 15 set does the following: status, prescaler, mask and count become 0, and compare becomes all ones. Control takes the written value with bits 15:10 cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | Write qualifier, sampled with busSel |
| busAddr | input | 6 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| fastTick | input | 1 | Fast tick-enable pulse, one clock per tick |
| slowTick | input | 1 | Slow tick-enable pulse, one clock per tick |
| irqOut | output | 1 | Level interrupt |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a wrap and a compare match. It is produced by putting the compare value at all ones in free-run mode and stepping the count through it. The status register must then read 0x21 after that single step. The second pair is a software write-one-to-clear of the compare flag and a fresh compare match. It is produced by driving the status write and a tick pulse in the same cycle, with the count sitting on the compare value. The compare flag must still read 1 afterwards, and the count must have moved on by one.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int PRE_W = 12;
  localparam int STAT_W = 6;

  localparam logic [3:0] IDX_CTRL = 4'd0;
  localparam logic [3:0] IDX_PRE  = 4'd1;
  localparam logic [3:0] IDX_STAT = 4'd2;
  localparam logic [3:0] IDX_MASK = 4'd3;
  localparam logic [3:0] IDX_CMP  = 4'd4;
  localparam logic [3:0] IDX_CNT  = 4'd9;

  // control bit positions (decoded by software, so fixed)
  localparam int B_EN   = 0;
  localparam int B_ENM  = 1;
  localparam int B_FREE = 9;
  localparam int B_SWR  = 15;

  typedef struct packed {
    logic             clear;    // zero count and prescale phase
    logic             enable;
    logic             freeRun;
    logic [2:0]       tickSel;
    logic [PRE_W-1:0] prescale;
  } ctrlStrobe_t;
endpackage

// File: rtl/match_timer_dp.sv
module match_timer_dp
  import match_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic             fastTick,
  input  logic             slowTick,
  output logic [CNT_W-1:0] count,
  output logic             matchEv,
  output logic             wrapEv
);
  logic [PRE_W-1:0] preCnt;
  logic srcTick, stepTick, preDone, advance, atCmp;

  always_comb begin
    unique case (strb.tickSel)
      3'b001, 3'b010: srcTick = fastTick;
      3'b100:         srcTick = slowTick;
      default:        srcTick = 1'b0;
    endcase
  end

  assign stepTick = strb.enable & srcTick & ~strb.clear;
  assign preDone  = (preCnt >= strb.prescale);
  assign advance  = stepTick & preDone;
  assign atCmp    = (count == cmpVal);
  assign matchEv  = advance & atCmp;
  assign wrapEv   = advance & strb.freeRun & (&count);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= '0;
    end else if (strb.clear) begin
      preCnt <= '0;
      count  <= '0;
    end else if (stepTick) begin
      preCnt <= preDone ? '0 : preCnt + 1'b1;
      if (advance)
        count <= (!strb.freeRun && atCmp) ? '0 : count + 1'b1;
    end
  end

  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !strb.clear) |=> $stable(count));

  assert_restart_on_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !strb.freeRun && atCmp) |=> (count == '0));

  assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (advance && strb.freeRun && (&count)) |=> (count == '0));
endmodule

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
  import match_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [3:0]       wordIdx,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             matchEv,
  input  logic             wrapEv,
  output ctrlStrobe_t      strb,
  output logic [CNT_W-1:0] cmpVal,
  output logic [31:0]      rdata,
  output logic             irq
);
  localparam logic [31:0] CTRL_KEEP = ~32'h0000_FC00;
  localparam logic [STAT_W-1:0] FLAG_MASK = 6'b10_0001;

  logic [31:0]       ctrlReg;
  logic [PRE_W-1:0]  preReg;
  logic [STAT_W-1:0] statReg, statNext, setMask, clrMask;
  logic [STAT_W-1:0] maskReg;
  logic [CNT_W-1:0]  cmpReg;
  logic wrCtrl, wrPre, wrStat, wrMask, wrCmp, swr, enRise;

  assign wrCtrl = wrEn && (wordIdx == IDX_CTRL);
  assign wrPre  = wrEn && (wordIdx == IDX_PRE);
  assign wrStat = wrEn && (wordIdx == IDX_STAT);
  assign wrMask = wrEn && (wordIdx == IDX_MASK);
  assign wrCmp  = wrEn && (wordIdx == IDX_CMP);
  assign swr    = wrCtrl && wdata[B_SWR];
  assign enRise = wrCtrl && wdata[B_EN] && !ctrlReg[B_EN];

  assign setMask  = {wrapEv, 4'b0000, matchEv};
  assign clrMask  = wrStat ? (wdata[STAT_W-1:0] & FLAG_MASK) : '0;
  assign statNext = swr ? '0 : ((statReg & ~clrMask) | setMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      preReg  <= '0;
      statReg <= '0;
      maskReg <= '0;
      cmpReg  <= '1;
    end else begin
      statReg <= statNext;
      if (wrCtrl) ctrlReg <= wdata & CTRL_KEEP;
      if (swr) begin
        preReg  <= '0;
        maskReg <= '0;
        cmpReg  <= '1;
      end
      if (wrPre)  preReg  <= wdata[PRE_W-1:0];
      if (wrMask) maskReg <= wdata[STAT_W-1:0];
      if (wrCmp)  cmpReg  <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    strb.clear    = swr || (enRise && wdata[B_ENM]) || (wrCmp && !ctrlReg[B_FREE]);
    strb.enable   = ctrlReg[B_EN];
    strb.freeRun  = ctrlReg[B_FREE];
    strb.tickSel  = ctrlReg[8:6];
    strb.prescale = preReg;
  end

  assign cmpVal = cmpReg;
  assign irq    = ctrlReg[B_EN] && |(statReg & maskReg & FLAG_MASK);

  always_comb begin
    unique case (wordIdx)
      IDX_CTRL: rdata = ctrlReg;
      IDX_PRE:  rdata = 32'(preReg);
      IDX_STAT: rdata = 32'(statReg);
      IDX_MASK: rdata = 32'(maskReg);
      IDX_CMP:  rdata = 32'(cmpReg);
      IDX_CNT:  rdata = 32'(count);
      default:  rdata = '0;
    endcase
  end

  assert_match_sets_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    matchEv |=> statReg[0]);

  assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrapEv |=> statReg[5]);

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && wdata[0] && !matchEv) |=> !statReg[0]);

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rstN)
    swr |=> (preReg == '0 && maskReg == '0 && statReg == '0 && (&cmpReg)));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [5:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        fastTick,
  input  logic        slowTick,
  output logic        irqOut
);
  ctrlStrobe_t      strb;
  logic [CNT_W-1:0] count, cmpVal;
  logic             matchEv, wrapEv;
  logic [1:0]       byteLane;

  assign byteLane = busAddr[1:0];

  match_timer_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .wrEn(busSel && busWrite && (byteLane == 2'b00)),
    .wordIdx(busAddr[5:2]), .wdata(busWdata),
    .count(count), .matchEv(matchEv), .wrapEv(wrapEv),
    .strb(strb), .cmpVal(cmpVal), .rdata(busRdata), .irq(irqOut)
  );

  match_timer_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpVal(cmpVal),
    .fastTick(fastTick), .slowTick(slowTick),
    .count(count), .matchEv(matchEv), .wrapEv(wrapEv)
  );
endmodule

// File: tb/match_timer_test.sv
`timescale 1ns/1ps
module match_timer_test;
  logic clk = 0, rstN = 0;
  logic busSel = 0, busWrite = 0, fastTick = 0, slowTick = 0;
  logic [5:0] busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic irqOut;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  match_timer #(.CNT_W(8)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .fastTick(fastTick), .slowTick(slowTick), .irqOut(irqOut));

  localparam logic [5:0] A_CTRL = 6'h00, A_PRE = 6'h04, A_STAT = 6'h08,
                         A_MASK = 6'h0C, A_CMP = 6'h10, A_CNT = 6'h24;

  // {prescaler, tick count, expected count}; restart mode, compare = 10
  localparam logic [47:0] VEC [8] = '{
    {16'd0, 16'd5,  16'd5}, {16'd0, 16'd11, 16'd0}, {16'd0, 16'd13, 16'd2},
    {16'd2, 16'd9,  16'd3}, {16'd2, 16'd10, 16'd3}, {16'd3, 16'd44, 16'd0},
    {16'd1, 16'd7,  16'd3}, {16'd4, 16'd60, 16'd1}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWrite = 0;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk); busAddr = a; #1;
    check(req, busRdata, exp);
  endtask

  task automatic irqChk(input string req, input logic exp);
    @(negedge clk); #1;
    check(req, {31'd0, irqOut}, {31'd0, exp});
  endtask

  task automatic ticks(input int n, input bit slow);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); if (slow) slowTick = 1; else fastTick = 1;
      @(negedge clk); slowTick = 0; fastTick = 0;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset values and unmapped reads
    rdChk("R1 ctrl reset", A_CTRL, 0);
    rdChk("R1 cmp reset", A_CMP, 32'hFF);
    rdChk("R1 cnt reset", A_CNT, 0);
    rdChk("R1 stat reset", A_STAT, 0);
    irqChk("R1 irq reset", 0);
    rdChk("R1 unmapped 0x14", 6'h14, 0);
    rdChk("R1 unmapped 0x3C", 6'h3C, 0);

    // R2 stored widths
    wr(A_CTRL, 32'h7C40); rdChk("R2 ctrl 14:10", A_CTRL, 32'h40);
    wr(A_PRE, 32'hFFFF);  rdChk("R2 prescaler width", A_PRE, 32'hFFF);
    wr(A_MASK, 32'hFF);   rdChk("R2 mask width", A_MASK, 32'h3F);

    // vector table: R4 prescale and R5 restart
    for (int i = 0; i < 8; i++) begin
      int p, n, e;
      p = int'(VEC[i][47:32]); n = int'(VEC[i][31:16]); e = int'(VEC[i][15:0]);
      wr(A_CTRL, 32'h8000);
      wr(A_PRE, p);
      wr(A_CMP, 10);
      wr(A_CTRL, 32'h41);
      ticks(n, 0);
      rdChk("R4 R5 vector count", A_CNT, e);
      rdChk("R5 vector flag", A_STAT, ((n / (p + 1)) >= 11) ? 1 : 0);
    end

    // R3 tick select
    wr(A_CTRL, 32'h8000);
    wr(A_CTRL, 32'h101);
    ticks(3, 0); rdChk("R3 slow src ignores fast", A_CNT, 0);
    ticks(2, 1); rdChk("R3 slow src counts", A_CNT, 2);
    wr(A_CTRL, 32'h001);
    ticks(2, 0); ticks(2, 1); rdChk("R3 code 000 no tick", A_CNT, 2);
    wr(A_CTRL, 32'h081);
    ticks(1, 0); rdChk("R3 code 010 fast", A_CNT, 3);
    // R4 disabled holds
    wr(A_CTRL, 32'h080);
    ticks(3, 0); rdChk("R4 hold while disabled", A_CNT, 3);
    // R9 enable-mode
    wr(A_CTRL, 32'h083); rdChk("R9 enmod clears", A_CNT, 0);
    ticks(2, 0);
    wr(A_CTRL, 32'h080); wr(A_CTRL, 32'h081);
    rdChk("R9 plain enable keeps", A_CNT, 2);
    // R10 compare write
    wr(A_CMP, 50); rdChk("R10 restart cmp write clears", A_CNT, 0);
    ticks(4, 0);
    wr(A_CTRL, 32'h281); wr(A_CMP, 60);
    rdChk("R10 freerun cmp write keeps", A_CNT, 4);

    // R5 / R8 / R7 interrupt path
    wr(A_CTRL, 32'h8000);
    wr(A_MASK, 1); wr(A_CMP, 2); wr(A_CTRL, 32'h41);
    ticks(2, 0);
    rdChk("R5 at compare", A_CNT, 2); irqChk("R8 no flag no irq", 0);
    ticks(1, 0);
    rdChk("R5 restart to 0", A_CNT, 0); rdChk("R5 flag set", A_STAT, 1);
    irqChk("R8 irq on", 1);
    wr(A_CTRL, 32'h40); irqChk("R8 disabled gates irq", 0);
    wr(A_CTRL, 32'h41); irqChk("R8 irq back", 1);
    wr(A_STAT, 32'h3E); rdChk("R7 other bits unwritable", A_STAT, 1);
    wr(A_STAT, 32'h01); rdChk("R7 w1c clears", A_STAT, 0);
    irqChk("R8 irq off after clear", 0);

    // R6 wrap and match in one step
    wr(A_CTRL, 32'h8000); wr(A_CTRL, 32'h241);
    ticks(255, 0);
    rdChk("R6 at all ones", A_CNT, 32'hFF); rdChk("R6 no flags yet", A_STAT, 0);
    ticks(1, 0);
    rdChk("R6 wrap to 0", A_CNT, 0); rdChk("R6 both flags", A_STAT, 32'h21);
    wr(A_MASK, 32'h01); wr(A_STAT, 32'h20);
    rdChk("R7 clear rollover only", A_STAT, 1); irqChk("R8 masked irq", 1);
    wr(A_MASK, 32'h20); irqChk("R8 mask mismatch", 0);

    // R6 free-run match only, then R7 set-vs-clear collision
    wr(A_CTRL, 32'h8000); wr(A_CTRL, 32'h241); wr(A_CMP, 5);
    ticks(6, 0);
    rdChk("R6 freerun passes compare", A_CNT, 6); rdChk("R6 match flag", A_STAT, 1);
    wr(A_CMP, 8); ticks(2, 0);
    @(negedge clk); busSel = 1; busWrite = 1; busAddr = A_STAT; busWdata = 1; fastTick = 1;
    @(negedge clk); busSel = 0; busWrite = 0; fastTick = 0;
    rdChk("R7 set wins over clear", A_STAT, 1);
    rdChk("R7 collision count", A_CNT, 9);

    // R11 soft reset
    wr(A_PRE, 3); wr(A_MASK, 32'h21);
    wr(A_CTRL, 32'h8241);
    rdChk("R11 ctrl keeps value", A_CTRL, 32'h241);
    rdChk("R11 prescaler", A_PRE, 0);
    rdChk("R11 mask", A_MASK, 0);
    rdChk("R11 status", A_STAT, 0);
    rdChk("R11 compare", A_CMP, 32'hFF);
    rdChk("R11 count", A_CNT, 0);

    done = 1;
    summary();
  end
endmodule